// File: doc/BRIEF.md
# Two-Wide Instruction Queue with Dispatch Interlock

This block is a small in-order buffer between instruction fetch and the execution units. Fetch may write zero, one or two instructions per cycle. The block reports how many slots are free, and it drops any instruction that does not fit. Each cycle, up to two instructions leave from the oldest end toward the units' reservation stations. Dispatch is combinational from the stored head entries, so an instruction that is dispatched is gone from the queue at the next clock edge.

A dispatch is held back by three things. The first is a registered scoreboard of destination registers still in flight: it is set when an instruction that writes a register dispatches, and cleared by writeback pulses. The second is a dependency between the two head instructions. The third is a serialization state machine with two states. In ST_FLOW, dispatch is allowed. When a serializing instruction dispatches, the machine moves from ST_FLOW to ST_HOLD. In ST_HOLD, nothing dispatches. The machine returns from ST_HOLD to ST_FLOW on a completion pulse. There are no other transitions.

Instructions written while a branch prediction is outstanding carry a speculative tag. A correct resolve clears the tags. A mispredict discards every tagged entry and keeps the older untagged ones in order.

Top module: `dual_issue_iq`

## Requirements
- R1: The queue holds at most 6 entries, and `free_cnt` always equals 6 minus the number of stored entries. After reset, `free_cnt` reads 6 and `disp_valid` is 0.
- R2: `enq_valid[0]` writes `enq_instr0`. `enq_valid[1]`, which is only meaningful together with bit 0, writes `enq_instr1` behind it. Slot k is written only when `free_cnt` is greater than k, and an offered instruction that does not fit is dropped. Entries leave in the order they were written.
- R3: Up to two entries leave per cycle, strictly from the oldest end. `disp_instr0` is the oldest entry and `disp_instr1` the next. `disp_valid[1]` is set only together with `disp_valid[0]`.
- R4: The instruction word is 19 bits wide. Bits [18:17] hold the unit type and bit 16 the destination-write enable. Bits [15:11] hold the destination register, [10:6] source A, [5:1] source B, and bit 0 the serializing flag.
- R5: The second entry does not dispatch unless the first dispatches in the same cycle. It also stays if the first writes a register (bit 16 set) that the second reads as source A or source B, or also writes.
- R6: An entry is blocked while its source A, its source B, or its destination (when bit 16 is set) is marked pending in the scoreboard. A blocked entry also blocks every younger entry. A pending mark is set the cycle after a writing entry dispatches, and is cleared the cycle after `wb_valid` with `wb_reg`. If a set and a clear for the same register fall in the same cycle, the set wins.
- R7: A serializing entry dispatches only from the first slot, and never together with a second entry. After it dispatches, nothing dispatches until a `ser_done` pulse arrives. Dispatch may resume in the cycle after that pulse. A `ser_done` pulse while the machine is in ST_FLOW has no effect.
- R8: An entry written while `pred_pending` is 1 is tagged speculative, and `disp_spec` shows the tag of each dispatched entry. A `resolve_ok` pulse clears the tags of all stored entries. Entries written in the same cycle as the pulse take their tag from `pred_pending`.
- R9: A `mispredict` pulse discards every tagged entry and keeps the untagged entries in order. In that cycle, nothing dispatches and any enqueue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 2 | Fetch write strobes, bit 0 for the older instruction |
| enq_instr0 | input | 19 | Older instruction from fetch |
| enq_instr1 | input | 19 | Younger instruction from fetch |
| free_cnt | output | 3 | Number of free slots |
| pred_pending | input | 1 | A branch prediction is unresolved |
| resolve_ok | input | 1 | Pulse: the prediction was correct |
| mispredict | input | 1 | Pulse: the prediction was wrong, flush tagged entries |
| wb_valid | input | 1 | Writeback pulse |
| wb_reg | input | 5 | Register written back |
| ser_done | input | 1 | Pulse: the serializing condition has cleared |
| disp_valid | output | 2 | Dispatch strobes, bit 0 for the oldest entry |
| disp_instr0 | output | 19 | Oldest entry, dispatched when `disp_valid[0]` |
| disp_instr1 | output | 19 | Second entry, dispatched when `disp_valid[1]` |
| disp_spec | output | 2 | Speculative tag of each dispatched entry |

## Verification
The assertions assume that the environment behaves as follows. `enq_valid` is never 2'b10. At most one prediction is outstanding at a time, so tagged entries always form the youngest run of the queue. `resolve_ok` and `mispredict` are never raised together. The stimulus generator follows these rules. It raises `pred_pending` from the first cycle of a prediction until the cycle of its single resolve pulse, and it picks either a correct resolve or a mispredict, never both. It does offer more instructions than `free_cnt` allows, and sends stray `ser_done` pulses in ST_FLOW, so that R2 and R7 are exercised on the dropping and ignoring paths.

// File: rtl/iq_pkg.sv
package iq_pkg;
    parameter int REG_W  = 5;
    parameter int UNIT_W = 2;
    localparam int NREG  = 1 << REG_W;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic              dst_en;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src_a;
        logic [REG_W-1:0]  src_b;
        logic              serial;
    } iq_instr_t;

    localparam int INSTR_W = $bits(iq_instr_t);

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } ser_state_t;
endpackage

// File: rtl/iq_store.sv
module iq_store import iq_pkg::*; #(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       enq_valid,
    input  iq_instr_t        enq_a,
    input  iq_instr_t        enq_b,
    input  logic             pred_pending,
    input  logic             resolve_ok,
    input  logic             flush,
    input  logic [1:0]       grant,
    output iq_instr_t        head_a,
    output iq_instr_t        head_b,
    output logic [1:0]       head_spec,
    output logic [1:0]       have,
    output logic [CNT_W-1:0] free
);
    iq_instr_t         mem [DEPTH];
    logic [DEPTH-1:0]  spec, spec_nxt;
    logic [PTR_W-1:0]  head, head1, tail_a, tail_b;
    logic [CNT_W-1:0]  count, pop_n, push_n, nspec;
    logic              wr_a, wr_b;

    function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] base, input int unsigned off);
        int unsigned s;
        s = int'(base) + off;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    assign head1   = wrap(head, 1);
    assign tail_a  = wrap(head, int'(count));
    assign tail_b  = wrap(tail_a, 1);
    assign free    = CNT_W'(DEPTH) - count;
    assign have    = {count >= CNT_W'(2), count >= CNT_W'(1)};
    assign head_a  = mem[head];
    assign head_b  = mem[head1];
    assign head_spec = {spec[head1], spec[head]};

    assign wr_a   = !flush && enq_valid[0] && (free >= CNT_W'(1));
    assign wr_b   = !flush && enq_valid[0] && enq_valid[1] && (free >= CNT_W'(2));
    assign pop_n  = CNT_W'(grant[0]) + CNT_W'(grant[1]);
    assign push_n = CNT_W'(wr_a) + CNT_W'(wr_b);
    assign nspec  = CNT_W'($countones(spec));

    always_comb begin
        spec_nxt = resolve_ok ? '0 : spec;
        if (grant[0]) spec_nxt[head]  = 1'b0;
        if (grant[1]) spec_nxt[head1] = 1'b0;
        if (wr_a) spec_nxt[tail_a] = pred_pending;
        if (wr_b) spec_nxt[tail_b] = pred_pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
            spec  <= '0;
        end else if (flush) begin
            count <= count - nspec;
            spec  <= '0;
        end else begin
            head  <= wrap(head, int'(pop_n));
            count <= count - pop_n + push_n;
            spec  <= spec_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_a) mem[tail_a] <= enq_a;
        if (wr_b) mem[tail_b] <= enq_b;
    end
endmodule

// File: rtl/iq_hazard.sv
module iq_hazard import iq_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  iq_instr_t        head_a,
    input  iq_instr_t        head_b,
    input  logic [1:0]       have,
    input  logic             allow,
    input  logic             wb_valid,
    input  logic [REG_W-1:0] wb_reg,
    output logic [1:0]       grant
);
    logic [NREG-1:0] busy, busy_nxt;
    logic            pair_dep;

    function automatic logic blocked(input iq_instr_t x, input logic [NREG-1:0] b);
        return b[x.src_a] | b[x.src_b] | (x.dst_en & b[x.dst]);
    endfunction

    assign pair_dep = head_a.dst_en &&
                      ((head_b.src_a == head_a.dst) || (head_b.src_b == head_a.dst) ||
                       (head_b.dst_en && (head_b.dst == head_a.dst)));

    assign grant[0] = allow && have[0] && !blocked(head_a, busy);
    assign grant[1] = grant[0] && have[1] && !head_a.serial && !head_b.serial &&
                      !blocked(head_b, busy) && !pair_dep;

    always_comb begin
        busy_nxt = busy;
        if (wb_valid) busy_nxt[wb_reg] = 1'b0;
        if (grant[0] && head_a.dst_en) busy_nxt[head_a.dst] = 1'b1;
        if (grant[1] && head_b.dst_en) busy_nxt[head_b.dst] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy <= '0;
        else        busy <= busy_nxt;
    end
endmodule

// File: rtl/iq_ser_fsm.sv
module iq_ser_fsm import iq_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_go,
    input  logic ser_done,
    input  logic flush,
    output logic allow
);
    ser_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FLOW: if (ser_go)   state_nxt = ST_HOLD;
            ST_HOLD: if (ser_done) state_nxt = ST_FLOW;
        endcase
    end

    always_comb begin
        allow = 1'b0;
        unique case (state)
            ST_FLOW: allow = !flush;
            ST_HOLD: allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_issue_iq.sv
module dual_issue_iq import iq_pkg::*; #(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         enq_valid,
    input  logic [INSTR_W-1:0] enq_instr0,
    input  logic [INSTR_W-1:0] enq_instr1,
    output logic [CNT_W-1:0]   free_cnt,
    input  logic               pred_pending,
    input  logic               resolve_ok,
    input  logic               mispredict,
    input  logic               wb_valid,
    input  logic [REG_W-1:0]   wb_reg,
    input  logic               ser_done,
    output logic [1:0]         disp_valid,
    output logic [INSTR_W-1:0] disp_instr0,
    output logic [INSTR_W-1:0] disp_instr1,
    output logic [1:0]         disp_spec
);
    iq_instr_t  head_a, head_b;
    logic [1:0] head_spec, have, grant;
    logic       allow;

    iq_store #(.DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid),
        .enq_a(iq_instr_t'(enq_instr0)), .enq_b(iq_instr_t'(enq_instr1)),
        .pred_pending(pred_pending), .resolve_ok(resolve_ok), .flush(mispredict),
        .grant(grant), .head_a(head_a), .head_b(head_b), .head_spec(head_spec),
        .have(have), .free(free_cnt)
    );

    iq_hazard hazard_i (
        .clk(clk), .rst_n(rst_n), .head_a(head_a), .head_b(head_b), .have(have),
        .allow(allow), .wb_valid(wb_valid), .wb_reg(wb_reg), .grant(grant)
    );

    iq_ser_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .ser_go(grant[0] && head_a.serial),
        .ser_done(ser_done), .flush(mispredict), .allow(allow)
    );

    assign disp_valid  = grant;
    assign disp_instr0 = head_a;
    assign disp_instr1 = head_b;
    assign disp_spec   = head_spec & grant;
endmodule

// File: rtl/dual_issue_iq_chk.sv
module dual_issue_iq_chk import iq_pkg::*; #(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mispredict,
    input logic [CNT_W-1:0]   free_cnt,
    input logic [1:0]         disp_valid,
    input logic [INSTR_W-1:0] disp_instr0
);
    iq_instr_t d0;
    assign d0 = iq_instr_t'(disp_instr0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(DEPTH)); // R1
    AST_ORDERED_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid[1] |-> disp_valid[0]); // R3
    AST_SERIAL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[0] && d0.serial) |-> !disp_valid[1]); // R7
    AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[0] && d0.serial) |=> (disp_valid == 2'b00)); // R7
    AST_RAW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[0] && d0.dst_en) |=>
        !(disp_valid[0] && ((d0.src_a == $past(d0.dst)) || (d0.src_b == $past(d0.dst))))); // R6
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> (disp_valid == 2'b00)); // R9
    AST_FLUSH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> (free_cnt >= $past(free_cnt))); // R9
endmodule

bind dual_issue_iq dual_issue_iq_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/dual_issue_iq_tb_top.sv
module dual_issue_iq_tb_top;
    import iq_pkg::*;
    localparam int DEPTH = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic [1:0] enq_valid, disp_valid, disp_spec;
    logic [INSTR_W-1:0] enq_instr0, enq_instr1, disp_instr0, disp_instr1;
    logic [2:0] free_cnt;
    logic pred_pending, resolve_ok, mispredict, wb_valid, ser_done;
    logic [REG_W-1:0] wb_reg;

    dual_issue_iq #(.DEPTH(DEPTH)) dut_i (.*);

    int checks = 0, fails = 0;
    bit finished = 0;

    iq_instr_t mq[$];
    bit        ms[$];
    bit [NREG-1:0] sb = '0;
    bit hold = 0, outst = 0;
    logic [31:0] rs = 32'h1234_5678;

    function automatic int unsigned rnd();
        rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
        return rs;
    endfunction

    function automatic bit dep(iq_instr_t x);
        return sb[x.src_a] || sb[x.src_b] || (x.dst_en && sb[x.dst]);
    endfunction

    function automatic bit pair(iq_instr_t a, iq_instr_t b);
        return a.dst_en && (b.src_a == a.dst || b.src_b == a.dst || (b.dst_en && b.dst == a.dst));
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit [1:0] ev, iq_instr_t a, iq_instr_t b, bit pred, bit rok,
                        bit bad, bit sd, bit wbv, bit [REG_W-1:0] wbr);
        bit g0, g1;
        int fr;
        string t0, t1;
        enq_valid = ev; enq_instr0 = a; enq_instr1 = b; pred_pending = pred;
        resolve_ok = rok; mispredict = bad; ser_done = sd; wb_valid = wbv; wb_reg = wbr;
        #1;
        g0 = !hold && !bad && mq.size() >= 1 && !dep(mq[0]);
        g1 = g0 && mq.size() >= 2 && !mq[0].serial && !mq[1].serial && !dep(mq[1]) && !pair(mq[0], mq[1]);
        t0 = bad ? "R9" : hold ? "R7" : (mq.size() >= 1 && dep(mq[0])) ? "R6" : "R3";
        t1 = !g0 ? "R5" : mq[0].serial ? "R7" : (mq.size() >= 2 && pair(mq[0], mq[1])) ? "R5" :
             (mq.size() >= 2 && dep(mq[1])) ? "R6" : "R3";
        chk(disp_valid[0] == g0, t0, "disp_valid[0]", disp_valid[0], g0);
        chk(disp_valid[1] == g1, t1, "disp_valid[1]", disp_valid[1], g1);
        if (g0) begin
            chk(disp_instr0 == mq[0], "R2", "disp_instr0", disp_instr0, mq[0]);
            chk(disp_spec[0] == ms[0], "R8", "disp_spec[0]", disp_spec[0], ms[0]);
        end
        if (g1) begin
            chk(disp_instr1 == mq[1], "R4", "disp_instr1", disp_instr1, mq[1]);
            chk(disp_spec[1] == ms[1], "R8", "disp_spec[1]", disp_spec[1], ms[1]);
        end
        fr = DEPTH - mq.size();
        chk(int'(free_cnt) == fr, "R1", "free_cnt", free_cnt, fr);
        @(posedge clk);
        if (hold && sd) hold = 0;
        if (wbv) sb[wbr] = 1'b0;
        if (bad) begin
            while (mq.size() > 0 && ms[$]) begin
                void'(mq.pop_back()); void'(ms.pop_back());
            end
        end else begin
            if (g0) begin
                if (mq[0].dst_en) sb[mq[0].dst] = 1'b1;
                if (mq[0].serial) hold = 1;
                void'(mq.pop_front()); void'(ms.pop_front());
            end
            if (g1) begin
                if (mq[0].dst_en) sb[mq[0].dst] = 1'b1;
                void'(mq.pop_front()); void'(ms.pop_front());
            end
            if (rok) foreach (ms[i]) ms[i] = 0;
            if (ev[0] && fr >= 1) begin mq.push_back(a); ms.push_back(pred); end
            if (ev == 2'b11 && fr >= 2) begin mq.push_back(b); ms.push_back(pred); end
        end
        @(negedge clk);
    endtask

    function automatic iq_instr_t mk();
        iq_instr_t x;
        x.unit   = UNIT_W'(rnd());
        x.dst_en = rnd() % 3 != 0;
        x.dst    = REG_W'(rnd() % 8);
        x.src_a  = REG_W'(rnd() % 8);
        x.src_b  = REG_W'(rnd() % 8);
        x.serial = (rnd() % 16) == 0;
        return x;
    endfunction

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; enq_valid = 0; enq_instr0 = '0; enq_instr1 = '0; pred_pending = 0;
        resolve_ok = 0; mispredict = 0; wb_valid = 0; wb_reg = '0; ser_done = 0;
        repeat (3) @(negedge clk);
        chk(free_cnt == 3'd6, "R1", "reset free_cnt", free_cnt, 6);
        chk(disp_valid == 2'b00, "R1", "reset disp_valid", disp_valid, 0);
        rst_n = 1;
        @(negedge clk);
        for (int n = 0; n < 6000; n++) begin
            bit [1:0] ev;
            bit pred, rok, bad, sd, wbv;
            int unsigned k;
            k = rnd() % 4;
            ev = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
            rok = 0; bad = 0;
            if (!outst && rnd() % 8 == 0) outst = 1;
            pred = outst;
            if (outst && rnd() % 10 == 0) begin
                if (rnd() % 2 == 0) rok = 1; else bad = 1;
                pred = 0; outst = 0;
            end
            sd = hold ? (rnd() % 4 == 0) : (rnd() % 16 == 0);
            wbv = rnd() % 2 == 0;
            step(ev, mk(), mk(), pred, rok, bad, sd, wbv, REG_W'(rnd() % 8));
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule